// File: doc/BRIEF.md
# Shared-Timebase Eight-Channel PWM Controller

This block produces eight pulse-width-modulated outputs from three shared timebase generators, named M, N and O. Each timebase divides a selected input tick stream by a two-field prescaler and then counts from zero up to a programmable 8-bit terminal value, so that a PWM cycle lasts (terminal + 1) prescaled ticks. Any output may follow any of the three timebases. A port drives high while its timebase's count is below the port's own 8-bit duty value.

Software configures the block through a plain write strobe with a small address and a 16-bit data word. A global control word starts and stops all timebases and chooses which of two tick-enable inputs advances them. One input is a fixed reference tick and the other is an alternate system tick. New prescaler, terminal and duty values are staged when written. They take effect at the next rollover of the timebase concerned, so no PWM cycle is ever cut short or stretched.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low and every configuration field is zero.
- R2: Address 0 holds the control word. Bit 0 is the run bit. While it is 0, all outputs are low and every timebase count is held at 0. Once it is set, each count starts from 0.
- R3: Bit 1 of the control word selects the tick input: 0 takes ref_tick and 1 takes alt_tick. A timebase advances only in cycles where the selected tick is high.
- R4: Addresses 1, 2 and 3 configure timebases M, N and O. Bits [3:0] hold the L field, decoded as a divide by 1 when 0 and by 2·L otherwise. Bits [7:4] hold the H field, decoded as a divide by 2^H. One prescaled tick occurs every (decoded L × decoded H) input ticks.
- R5: Bits [15:8] of a timebase word hold the terminal value P. The count runs 0..P and then wraps to 0, so one PWM cycle lasts (P+1) prescaled ticks.
- R6: Addresses 4 to 11 configure ports 0 to 7 (A to H). Bit 0 is the port enable (1 = on). Bits [2:1] select the timebase (0 = M, 1 = N, 2 = O), and the value 3 holds the port low. Bits [15:8] hold the duty value. A disabled port stays low.
- R7: An enabled port is high while its timebase count is less than its duty value. A duty of 0 gives a constant low, and a duty above P gives a constant high.
- R8: Written L, H, P and duty values take effect only at the next rollover of the affected timebase. They take effect at once while the run bit is 0 or while the port selects no timebase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference tick enable |
| alt_tick | input | 1 | Alternate system tick enable |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration word address |
| wr_data | input | 16 | Configuration write data |
| pwm_out | output | 8 | PWM outputs, bit k is port k |

## Verification
The bench counts high cycles over exact multiples of each timebase's cycle, so any wrong L step, H power or off-by-one terminal changes the measured total. It tests duty 0, duty equal to P+1 and duty far above P. A compare with the wrong sense or bound would show stray pulses or missing ones. Selector value 3 and a cleared enable must give silence. The alternate tick, arriving every other cycle, must exactly double every high count; a design that ignores the select would show the undoubled count. A duty write made mid-cycle must leave the current cycle's high time unchanged and then show up in full in the next cycle, which catches a design that applies it at once.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    parameter int NPORT = 8;
    parameter int NTB   = 3;
    parameter int LW    = 4;
    parameter int HW    = 4;
    parameter int PW    = 8;
    parameter int AW    = 4;
    parameter int DW    = 16;
    localparam int SELW      = $clog2(NTB + 1);
    localparam int DIVW      = LW + 1 + (2 ** HW) - 1;
    localparam int PORT_BASE = 1 + NTB;

    typedef struct packed {
        logic [PW-1:0] period;
        logic [HW-1:0] h;
        logic [LW-1:0] l;
    } tb_cfg_t;

    typedef struct packed {
        logic [PW-1:0]   duty;
        logic [SELW-1:0] sel;
        logic            en;
    } port_cfg_t;

    typedef struct packed {
        logic src;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_bank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  tb_cfg_t       cfg_in,
    output logic [PW-1:0] cnt,
    output logic [PW-1:0] period,
    output logic          wrap
);
    typedef struct packed {
        logic [DIVW-1:0] pre;
        logic [PW-1:0]   cnt;
        tb_cfg_t         act;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [LW:0]     l_dec;
    logic [DIVW-1:0] div;
    logic            pre_last;

    always_comb begin
        st_d     = st_q;
        l_dec    = (st_q.act.l == '0) ? (LW+1)'(1) : {st_q.act.l, 1'b0};
        div      = DIVW'(l_dec) << st_q.act.h;
        pre_last = (st_q.pre == div - DIVW'(1));
        wrap     = run && tick && pre_last && (st_q.cnt == st_q.act.period);
        if (!run) begin
            st_d.pre = '0;
            st_d.cnt = '0;
            st_d.act = cfg_in;
        end else if (tick) begin
            if (pre_last) begin
                st_d.pre = '0;
                if (st_q.cnt == st_q.act.period) begin
                    st_d.cnt = '0;
                    st_d.act = cfg_in;
                end else begin
                    st_d.cnt = st_q.cnt + PW'(1);
                end
            end else begin
                st_d.pre = st_q.pre + DIVW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign period = st_q.act.period;
endmodule

// File: rtl/pwm_port_ch.sv
module pwm_port_ch
    import pwm_bank_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  port_cfg_t               cfg,
    input  logic [NTB-1:0][PW-1:0]  cnt,
    input  logic [NTB-1:0]          wrap,
    output logic                    out,
    output logic [PW-1:0]           duty_act
);
    typedef struct packed {
        logic [PW-1:0] duty;
    } ch_state_t;

    ch_state_t     st_d, st_q;
    logic [PW-1:0] cur_cnt;
    logic          cur_wrap;
    logic          hit;

    always_comb begin
        cur_cnt  = '0;
        cur_wrap = 1'b0;
        hit      = 1'b0;
        for (int i = 0; i < NTB; i++) begin
            if (cfg.sel == SELW'(i)) begin
                cur_cnt  = cnt[i];
                cur_wrap = wrap[i];
                hit      = 1'b1;
            end
        end
        st_d = st_q;
        if (!run || !hit || cur_wrap) st_d.duty = cfg.duty;
        out = run && cfg.en && hit && (cur_cnt < st_q.duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign duty_act = st_q.duty;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             alt_tick,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [NPORT-1:0] pwm_out
);
    typedef struct packed {
        ctrl_t                       ctrl;
        tb_cfg_t   [NTB-1:0]         tb;
        port_cfg_t [NPORT-1:0]       port;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                         run_w;
    logic                         tick_w;
    logic [NTB-1:0][PW-1:0]       tb_cnt;
    logic [NTB-1:0][PW-1:0]       tb_per;
    logic [NTB-1:0]               tb_wrap;
    logic [NPORT-1:0][PW-1:0]     port_duty;
    logic [NPORT-1:0]             port_en_w;
    logic [NPORT-1:0][SELW-1:0]   port_sel_w;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == AW'(0)) regs_d.ctrl = ctrl_t'(wr_data[1:0]);
            for (int i = 0; i < NTB; i++) begin
                if (wr_addr == AW'(1 + i)) regs_d.tb[i] = tb_cfg_t'(wr_data[PW+HW+LW-1:0]);
            end
            for (int k = 0; k < NPORT; k++) begin
                if (wr_addr == AW'(PORT_BASE + k))
                    regs_d.port[k] = {wr_data[DW-1:DW-PW], wr_data[SELW:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign run_w  = regs_q.ctrl.run;
    assign tick_w = regs_q.ctrl.src ? alt_tick : ref_tick;

    generate
        for (genvar i = 0; i < NTB; i++) begin : g_tb
            pwm_timebase u_tb (
                .clk    (clk),
                .rst_n  (rst_n),
                .run    (run_w),
                .tick   (tick_w),
                .cfg_in (regs_q.tb[i]),
                .cnt    (tb_cnt[i]),
                .period (tb_per[i]),
                .wrap   (tb_wrap[i])
            );
        end
        for (genvar k = 0; k < NPORT; k++) begin : g_port
            pwm_port_ch u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .run      (run_w),
                .cfg      (regs_q.port[k]),
                .cnt      (tb_cnt),
                .wrap     (tb_wrap),
                .out      (pwm_out[k]),
                .duty_act (port_duty[k])
            );
            assign port_en_w[k]  = regs_q.port[k].en;
            assign port_sel_w[k] = regs_q.port[k].sel;
        end
    endgenerate
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       run,
    input logic [NPORT-1:0]           pwm_out,
    input logic [NPORT-1:0]           port_en,
    input logic [NPORT-1:0][SELW-1:0] port_sel,
    input logic [NPORT-1:0][PW-1:0]   duty_act,
    input logic [NTB-1:0][PW-1:0]     cnt,
    input logic [NTB-1:0][PW-1:0]     per_act,
    input logic [NTB-1:0]             wrap
);
    p_run_off_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_out == '0));

    generate
        for (genvar i = 0; i < NTB; i++) begin : g_tb_chk
            p_run_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> (cnt[i] == '0));
            p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
                run |-> (cnt[i] <= per_act[i]));
            p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
                wrap[i] |=> (cnt[i] == '0));
            p_period_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (run && !wrap[i]) |=> $stable(per_act[i]));
        end
        for (genvar k = 0; k < NPORT; k++) begin : g_port_chk
            p_disabled_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!port_en[k] || port_sel[k] >= SELW'(NTB)) |-> !pwm_out[k]);
            p_duty_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (duty_act[k] == '0) |-> !pwm_out[k]);
        end
    endgenerate
endmodule

bind pwm_bank pwm_bank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .pwm_out  (pwm_out),
    .port_en  (port_en_w),
    .port_sel (port_sel_w),
    .duty_act (port_duty),
    .cnt      (tb_cnt),
    .per_act  (tb_per),
    .wrap     (tb_wrap)
);

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        alt_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  pwm_out;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    int cl[3], ch[3], cp[3];
    int pen[8], psel[8], pduty[8];
    int hi[8], win[8];

    pwm_bank dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .alt_tick(alt_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;
    always @(negedge clk) alt_tick <= ~alt_tick;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout, expected completion");
            finish_run();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int vdiv(input int l, input int h);
        return ((l == 0) ? 1 : 2 * l) * (1 << h);
    endfunction

    function automatic int tcyc(input int t, input int step);
        return step * (cp[t] + 1) * vdiv(cl[t], ch[t]);
    endfunction

    function automatic int exp_hi(input int p, input int step, input int nper);
        int t, d;
        if (pen[p] == 0 || psel[p] > 2) return 0;
        t = psel[p];
        d = (pduty[p] < cp[t] + 1) ? pduty[p] : cp[t] + 1;
        return nper * step * vdiv(cl[t], ch[t]) * d;
    endfunction

    task automatic program_and_run(input int src);
        wr(0, src << 1);
        for (int t = 0; t < 3; t++) wr(1 + t, (cp[t] << 8) | (ch[t] << 4) | cl[t]);
        for (int p = 0; p < 8; p++) wr(4 + p, (pduty[p] << 8) | (psel[p] << 1) | pen[p]);
        wr(0, (src << 1) | 1);
    endtask

    task automatic measure(input int src, input string tag);
        int step, maxw;
        step = src ? 2 : 1;
        maxw = 0;
        for (int p = 0; p < 8; p++) begin
            win[p] = 2 * tcyc((psel[p] > 2) ? 0 : psel[p], step);
            hi[p]  = 0;
            if (win[p] > maxw) maxw = win[p];
        end
        program_and_run(src);
        for (int k = 0; k < maxw; k++) begin
            for (int p = 0; p < 8; p++) if (k < win[p] && pwm_out[p]) hi[p]++;
            @(negedge clk);
        end
        for (int p = 0; p < 8; p++) begin
            int e;
            e = exp_hi(p, step, 2);
            check(hi[p] == e, $sformatf("%s port %0d high cycles", tag, p), hi[p], e);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pwm_out == 8'h00, "R1 reset outputs", int'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == 8'h00, "R1 outputs after reset release", int'(pwm_out), 0);

        // Directed: R4 R5 R6 R7 across all three timebases
        cl = '{5, 0, 2}; ch = '{0, 2, 1}; cp = '{95, 9, 3};
        pen   = '{1, 1, 1, 1, 0, 1, 1, 1};
        psel  = '{0, 1, 2, 0, 0, 3, 1, 0};
        pduty = '{48, 5, 200, 0, 20, 30, 10, 1};
        measure(0, "R4_R5_R6_R7 directed");

        // R2: run bit cleared forces all low
        begin
            int bad;
            bad = 0;
            wr(0, 0);
            for (int k = 0; k < 50; k++) begin
                if (pwm_out != 8'h00) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R2 run off outputs low", bad, 0);
        end

        // R3: alternate tick at half rate doubles every high count
        measure(1, "R3 alt tick");

        // R8: duty written mid-cycle takes effect at next rollover
        begin
            int h0, h1;
            cl = '{0, 0, 0}; ch = '{0, 0, 0}; cp = '{99, 0, 0};
            pen = '{1, 0, 0, 0, 0, 0, 0, 0};
            psel = '{0, 0, 0, 0, 0, 0, 0, 0};
            pduty = '{50, 0, 0, 0, 0, 0, 0, 0};
            program_and_run(0);
            h0 = 0; h1 = 0;
            for (int k = 0; k < 200; k++) begin
                if (pwm_out[0]) begin
                    if (k < 100) h0++; else h1++;
                end
                if (k == 10) begin
                    wr_en = 1'b1; wr_addr = 4'd4; wr_data = {8'd80, 8'h01};
                end
                if (k == 11) wr_en = 1'b0;
                @(negedge clk);
            end
            check(h0 == 50, "R8 current cycle keeps old duty", h0, 50);
            check(h1 == 80, "R8 next cycle uses new duty", h1, 80);
        end

        // Random: R4 R5 R6 R7
        for (int it = 0; it < 6; it++) begin
            for (int t = 0; t < 3; t++) begin
                cl[t] = $urandom % 4;
                ch[t] = $urandom % 3;
                cp[t] = 3 + $urandom % 18;
            end
            for (int p = 0; p < 8; p++) begin
                pen[p]  = ($urandom % 5 != 0) ? 1 : 0;
                psel[p] = $urandom % 4;
                pduty[p] = $urandom % (cp[(psel[p] > 2) ? 0 : psel[p]] + 4);
            end
            measure(0, $sformatf("R4_R5_R7 random %0d", it));
        end

        finish_run();
    end
endmodule